// File: doc/BRIEF.md
# Configuration Word Checksum Checker

This block validates a block of configuration words as it streams past. Each accepted word is a 16-bit value, and a marker on the input flags the final word of the block. All words before the final one are added into a wide running sum. The final word is taken as the stored checksum. One cycle after that word, the block raises a one-cycle `done` together with exactly one of `pass` or `fail`.

A verdict of pass needs two conditions. The full-width sum must be nonzero, and its low 16 bits must equal the stored checksum. A `start` pulse throws away any partial sum, so a new block can begin. After a verdict, the sum also returns to zero on its own, which lets streams follow each other back to back. The block does not fetch the words from storage and does not repair bad data.

Top module: `cfg_cksum_check`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done`, `pass` and `fail` are all low.
- R2: A word accepted with `word_last` high in clock cycle N makes `done` high for exactly cycle N+1. `done` is never high at any other time.
- R3: When the sum of all words before the final one is nonzero, and its low 16 bits equal the final word, the verdict is pass (`pass`=1, `fail`=0).
- R4: When the low 16 bits of the sum differ from the final word, the verdict is fail (`pass`=0, `fail`=1).
- R5: When the full 32-bit sum is exactly zero, the verdict is fail, even if the final word is also zero.
- R6: A stream made of the final word alone has a zero sum, so it always fails.
- R7: The sum is kept 32 bits wide, so carries out of bit 15 are retained. For example, words 0xFFFF and 0x0001 followed by checksum 0x0000 pass, because the sum 0x10000 is nonzero.
- R8: `pass` and `fail` are high only while `done` is high, and then exactly one of them is high.
- R9: A cycle with `start` high clears the running sum. A word presented in that same cycle is ignored: it is not added, and it does not produce a verdict even when `word_last` is high.
- R10: Cycles with `word_valid` low leave the sum unchanged, whatever is on `word_data`.
- R11: After a final word, the sum restarts from zero, so the next stream needs no `start` pulse and may begin in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the running sum; a word presented in the same cycle is dropped |
| word_valid | input | 1 | `word_data` carries a word this cycle |
| word_data | input | 16 | Configuration word, or the stored checksum when `word_last` is high |
| word_last | input | 1 | Marks the final word of the stream |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Checksum valid; meaningful only while `done` is high |
| fail | output | 1 | Checksum invalid or zero sum; meaningful only while `done` is high |

## Verification
The bench builds the block with its default sizes: 16-bit words and a 32-bit sum. With a sum twice as wide as a word, a stream of two or three words is enough to carry past bit 15. That makes the difference between the wide zero test and a 16-bit one visible, both for a passing sum of 0x10000 and for a truly zero sum. Wrap-around of the 32-bit sum itself would need more than 65536 words, so it lies outside the streams the bench drives.

// File: rtl/cfg_cksum_pkg.sv
package cfg_cksum_pkg;

  // Registered outcome of one checked stream.
  typedef struct packed {
    logic done;
    logic pass;
    logic fail;
  } verdict_t;

  localparam verdict_t VERDICT_IDLE = '{done: 1'b0, pass: 1'b0, fail: 1'b0};

endpackage

// File: rtl/cfg_cksum_accum.sv
// Running sum of the non-final words; cleared by reset, start, or end of stream.
module cfg_cksum_accum #(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add_en,
  input  logic              restart,
  input  logic [WORD_W-1:0] add_val,
  output logic [ACC_W-1:0]  sum
);
  localparam int PAD_W = ACC_W - WORD_W;

  logic [ACC_W-1:0] add_ext;
  assign add_ext = {{PAD_W{1'b0}}, add_val};

  always_ff @(posedge clk) begin
    if (rst || clr || restart) begin
      sum <= '0;
    end else if (add_en) begin
      sum <= sum + add_ext;
    end
  end
endmodule

// File: rtl/cfg_cksum_judge.sv
// Compares the sum with the stored checksum and registers the verdict.
module cfg_cksum_judge
  import cfg_cksum_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              finish,
  input  logic [ACC_W-1:0]  sum,
  input  logic [WORD_W-1:0] stored,
  output verdict_t          verdict
);
  logic sum_is_zero;
  logic low_match;
  logic good;

  assign sum_is_zero = (sum == '0);
  assign low_match   = (sum[WORD_W-1:0] == stored);
  assign good        = low_match && !sum_is_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict <= VERDICT_IDLE;
    end else if (finish) begin
      verdict <= '{done: 1'b1, pass: good, fail: !good};
    end else begin
      verdict <= VERDICT_IDLE;
    end
  end
endmodule

// File: rtl/cfg_cksum_check.sv
module cfg_cksum_check
  import cfg_cksum_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_last,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  logic             accept;
  logic             add_en;
  logic             finish;
  logic [ACC_W-1:0] sum;
  verdict_t         verdict;

  // A start cycle swallows any word presented alongside it.
  assign accept = word_valid && !start;
  assign add_en = accept && !word_last;
  assign finish = accept && word_last;

  cfg_cksum_accum #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .add_en  (add_en),
    .restart (finish),
    .add_val (word_data),
    .sum     (sum)
  );

  cfg_cksum_judge #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_judge (
    .clk     (clk),
    .rst     (rst),
    .finish  (finish),
    .sum     (sum),
    .stored  (word_data),
    .verdict (verdict)
  );

  assign done = verdict.done;
  assign pass = verdict.pass;
  assign fail = verdict.fail;
endmodule

// File: rtl/cfg_cksum_check_props.sv
module cfg_cksum_check_props (
  input logic clk,
  input logic rst,
  input logic start,
  input logic word_valid,
  input logic word_last,
  input logic done,
  input logic pass,
  input logic fail
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!done && !pass && !fail));

  p_done_follows_last_r2: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_last && !start) |=> done);

  p_done_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(word_valid && word_last && !start));

  p_one_verdict_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({pass, fail}));

  p_flags_need_done_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!pass && !fail));

  p_start_drops_word_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);
endmodule

bind cfg_cksum_check cfg_cksum_check_props u_props (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .word_valid (word_valid),
  .word_last  (word_last),
  .done       (done),
  .pass       (pass),
  .fail       (fail)
);

// File: tb/cfg_cksum_check_test.sv
module cfg_cksum_check_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_last = 1'b0;
  logic [15:0] word_data = 16'hFFFF;
  logic        done, pass, fail;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  int          exp_cyc_q[$];
  bit          exp_pass_q[$];
  string       exp_tag_q[$];
  logic [15:0] stim[$];

  cfg_cksum_check uut (
    .clk(clk), .rst(rst), .start(start), .word_valid(word_valid),
    .word_data(word_data), .word_last(word_last),
    .done(done), .pass(pass), .fail(fail)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // One input cycle; idle data is driven to all ones so that ignored words matter.
  task automatic put(input logic [15:0] w, input bit last, input bit st);
    word_valid = 1'b1; word_data = w; word_last = last; start = st;
    @(negedge clk);
    word_valid = 1'b0; word_data = 16'hFFFF; word_last = 1'b0; start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: computes the expected verdict from stim and queues it.
  task automatic run_stream(input string tag, input int gap);
    logic [31:0] s;
    bit ok;
    s = '0;
    for (int i = 0; i < stim.size() - 1; i++) s = s + {16'h0, stim[i]};
    ok = (s != 0) && (s[15:0] == stim[stim.size()-1]);
    for (int i = 0; i < stim.size(); i++) begin
      if (i == stim.size() - 1) begin
        exp_cyc_q.push_back(cyc + 1);
        exp_pass_q.push_back(ok);
        exp_tag_q.push_back(tag);
        put(stim[i], 1'b1, 1'b0);
      end else begin
        put(stim[i], 1'b0, 1'b0);
        idle(gap);
      end
    end
  endtask

  // Monitor: pops expectations as verdicts appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (exp_pass_q.size() == 0) begin
          chk(1'b0, "R2/R9 unexpected done", 1, 0);
        end else begin
          int    ec;
          bit    ep;
          string t;
          ec = exp_cyc_q.pop_front();
          ep = exp_pass_q.pop_front();
          t  = exp_tag_q.pop_front();
          chk(cyc == ec, {t, " R2 done cycle"}, cyc, ec);
          chk(pass == ep, {t, " pass"}, int'(pass), int'(ep));
          chk(fail == !ep, {t, " R8 fail flag"}, int'(fail), int'(!ep));
        end
      end else if (pass || fail) begin
        chk(1'b0, "R8 flag without done", int'({pass, fail}), 0);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    chk(!done && !pass && !fail, "R1 outputs in reset", int'({done, pass, fail}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !pass && !fail, "R1 outputs after reset", int'({done, pass, fail}), 0);

    stim = {16'd3, 16'd5, 16'd7, 16'd15};        run_stream("R3 match", 0);
    idle(2);
    stim = {16'd3, 16'd5, 16'd7, 16'd16};        run_stream("R4 mismatch", 0);
    idle(2);
    stim = {16'h0000, 16'h0000, 16'h0000};        run_stream("R5 zero sum", 0);
    idle(2);
    stim = {16'h0000};                            run_stream("R6 lone zero", 0);
    idle(1);
    stim = {16'h1234};                            run_stream("R6 lone word", 0);
    idle(2);
    stim = {16'hFFFF, 16'h0001, 16'h0000};        run_stream("R7 carry 0x10000", 0);
    idle(2);
    stim = {16'h8000, 16'h8000, 16'h0005, 16'h0005}; run_stream("R7 carry plus", 0);
    idle(2);
    stim = {16'h0101, 16'h0202, 16'h0303, 16'h0606}; run_stream("R10 gaps", 3);
    idle(2);

    // R9: partial sum discarded by start
    put(16'h0100, 1'b0, 1'b0);
    put(16'h0000, 1'b0, 1'b1);
    stim = {16'd1, 16'd2, 16'd3};                 run_stream("R9 cleared", 0);
    idle(2);
    // R9: last word with start is dropped, no verdict
    put(16'd4, 1'b0, 1'b0);
    put(16'd4, 1'b1, 1'b1);
    idle(3);
    stim = {16'd2, 16'd2};                        run_stream("R9 after drop", 0);
    idle(2);

    // R11: back-to-back streams without start
    stim = {16'd10, 16'd20, 16'd30};              run_stream("R11 first", 0);
    stim = {16'd1, 16'd1};                        run_stream("R11 second", 0);
    stim = {16'd9, 16'd8};                        run_stream("R11 third", 0);
    idle(4);

    chk(exp_pass_q.size() == 0, "R2 all verdicts seen", exp_pass_q.size(), 0);
    summary();
    $finish;
  end
endmodule